// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block sits between a host processor and an embedded controller and carries one command at a time from the first to the second. The host sees a 256-byte window of 32-bit word registers on a simple register bus with a write strobe and a combinational read path. To issue a command, the host loads its payload and any pointers, then writes a command word. That write rings a doorbell toward the controller and marks the mailbox busy.

The controller sees the decoded command fields, both pointers and the payload words through an index port. It can place response words in a read buffer that the host can see. It finishes the command with a one-cycle done strobe that carries an error flag and an 8-bit error code. If the command asked for it, the host then receives a single-cycle completion pulse that needs no acknowledgement. A command word written while a command is still outstanding is discarded, and a sticky overrun flag reports this to the controller.

Addresses are word aligned and bits [1:0] of the host address are not decoded. The offsets are: command 0x00 (write-only), status 0x04 (read-only), source pointer 0x08 and destination pointer 0x0C (both write-only), payload buffer 0x80–0x8C (write-only, word i at 0x80+4i) and response buffer 0x90–0x9C (read-only, word i at 0x90+4i).

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the busy flag, error flag, error code, overrun flag, both pointers, all payload and response words, the doorbell and the host interrupt are all zero.
- R2: A host write to offset 0x00 while idle is accepted. The doorbell goes high for exactly one cycle after the write edge and busy is set. The controller sees opcode = bits [7:0], completion-interrupt request = bit 8, command id = bits [15:12] and size = bits [23:16] of the written word.
- R3: A read of offset 0x04 returns {8'h00, error code, INIT_ID, command id, 2'b00, error, busy}, with busy in bit 0, error in bit 1, command id in bits [7:4], the initiator id in bits [15:8] and the error code in bits [23:16].
- R4: A done strobe while busy clears busy and latches the error flag and error code on the same edge. Those values are held until the next completion. A done strobe while idle changes nothing.
- R5: When the completed command had bit 8 set, the host interrupt is high for exactly the one cycle after the completing edge. When bit 8 was clear, no pulse is produced.
- R6: A command write while busy is dropped: no doorbell, and the latched command fields are unchanged. It sets the overrun flag, which then stays set until reset.
- R7: Host writes to 0x08, 0x0C and 0x80+4i are stored at all times, busy or not, and appear on the controller's pointer and payload ports.
- R8: The controller writes response word i through its write port, and the host reads it at 0x90+4i. Host writes to 0x04 and to the response buffer have no effect.
- R9: Host reads of the write-only offsets (0x00, 0x08, 0x0C, 0x80–0x8C) and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 8 | Host byte address within the window |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, combinational from hostAddr |
| hostIrq | output | 1 | One-cycle completion pulse to the host |
| ctlDoorbell | output | 1 | One-cycle new-command pulse to the controller |
| ctlOpcode | output | 8 | Latched command opcode |
| ctlIoc | output | 1 | Latched completion-interrupt request |
| ctlCmdId | output | 4 | Latched command id |
| ctlSize | output | 8 | Latched payload size |
| ctlSrcPtr | output | 32 | Source pointer |
| ctlDstPtr | output | 32 | Destination pointer |
| ctlWbufIdx | input | 2 | Payload word select |
| ctlWbufData | output | 32 | Selected payload word |
| ctlRbufWe | input | 1 | Response word write enable |
| ctlRbufIdx | input | 2 | Response word select |
| ctlRbufData | input | 32 | Response word data |
| ctlDone | input | 1 | Completion strobe |
| ctlErr | input | 1 | Error flag sampled with ctlDone |
| ctlErrCode | input | 8 | Error code sampled with ctlDone |
| ctlOverrun | output | 1 | Sticky dropped-command flag |
| busy | output | 1 | Command outstanding |

## Verification
The assertions check the following on every cycle: the doorbell appears only after an accepted command write, busy rises only together with the doorbell, and a completion while busy always clears busy. They also check that the host interrupt comes only from a completion of a command that requested it and lasts a single cycle, that overrun never clears, and that response words change only when written. The bench scenarios cover the rest: the exact bit packing of status and command fields, that a command dropped while busy leaves the latched fields alone, that payload writes are taken while busy, that a done strobe while idle is ignored, and that write-only and read-only offsets behave as stated.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;
  localparam int OFF_CMD  = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_SRC  = 'h08;
  localparam int OFF_DST  = 'h0C;
  localparam int OFF_WBUF = 'h80;

  typedef struct packed {
    logic [7:0] rsvdHi;
    logic [7:0] size;
    logic [3:0] cmdId;
    logic [2:0] rsvdLo;
    logic       ioc;
    logic [7:0] opcode;
  } cmdWord_t;

  typedef struct packed {
    logic cmdWr;
    logic srcWr;
    logic dstWr;
    logic wbufWr;
    logic doneLatch;
  } hostStrobe_t;
endpackage

// File: rtl/ipcmb_ctrl.sv
module ipcmb_ctrl
  import ipcmb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 4,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              ctlDone,
  input  logic              latchedIoc,
  output hostStrobe_t       strobe,
  output logic [IDX_W-1:0]  wbufIdx,
  output logic              busy,
  output logic              doorbell,
  output logic              hostIrq,
  output logic              overrun
);
  localparam int BUF_BYTES = BUF_WORDS * 4;

  logic isCmd, isSrc, isDst, isWbuf, doneOk, dropCmd;
  int   addrInt;

  always_comb begin
    addrInt = int'(hostAddr) & ~3;
    isCmd   = addrInt == OFF_CMD;
    isSrc   = addrInt == OFF_SRC;
    isDst   = addrInt == OFF_DST;
    isWbuf  = addrInt >= OFF_WBUF && addrInt < OFF_WBUF + BUF_BYTES;
    wbufIdx = IDX_W'((addrInt - OFF_WBUF) >> 2);
    doneOk  = ctlDone && busy;
    dropCmd = hostWrEn && isCmd && busy;
    strobe.cmdWr     = hostWrEn && isCmd && !busy;
    strobe.srcWr     = hostWrEn && isSrc;
    strobe.dstWr     = hostWrEn && isDst;
    strobe.wbufWr    = hostWrEn && isWbuf;
    strobe.doneLatch = doneOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      doorbell <= 1'b0;
      hostIrq  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (strobe.cmdWr)  busy <= 1'b1;
      else if (doneOk)   busy <= 1'b0;
      doorbell <= strobe.cmdWr;
      hostIrq  <= doneOk && latchedIoc;
      overrun  <= overrun | dropCmd;
    end
  end

  // R2
  doorbell_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doorbell |-> $past(hostWrEn && isCmd && !busy));
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> doorbell);
  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlDone && busy) |=> !busy);
  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> $past(ctlDone && busy && latchedIoc));
  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |=> !hostIrq);
  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
endmodule

// File: rtl/ipcmb_datapath.sv
module ipcmb_datapath
  import ipcmb_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int BUF_WORDS     = 4,
  parameter logic [7:0] INIT_ID = 8'h5A,
  localparam int IDX_W        = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobe,
  input  logic [IDX_W-1:0]  wbufIdx,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  input  logic              busy,
  input  logic              ctlErr,
  input  logic [7:0]        ctlErrCode,
  input  logic [IDX_W-1:0]  ctlWbufIdx,
  input  logic              ctlRbufWe,
  input  logic [IDX_W-1:0]  ctlRbufIdx,
  input  logic [31:0]       ctlRbufData,
  output cmdWord_t          cmdReg,
  output logic [31:0]       srcPtr,
  output logic [31:0]       dstPtr,
  output logic [31:0]       ctlWbufData,
  output logic [31:0]       hostRdata
);
  localparam int BUF_BYTES = BUF_WORDS * 4;
  localparam int OFF_RBUF  = OFF_WBUF + BUF_BYTES;

  logic [31:0] wbuf [BUF_WORDS];
  logic [31:0] rbuf [BUF_WORDS];
  logic        errFlag;
  logic [7:0]  errCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      srcPtr  <= '0;
      dstPtr  <= '0;
      errFlag <= 1'b0;
      errCode <= '0;
    end else begin
      if (strobe.cmdWr) cmdReg <= cmdWord_t'(hostWdata);
      if (strobe.srcWr) srcPtr <= hostWdata;
      if (strobe.dstWr) dstPtr <= hostWdata;
      if (strobe.doneLatch) begin
        errFlag <= ctlErr;
        errCode <= ctlErrCode;
      end
    end
  end

  for (genvar g = 0; g < BUF_WORDS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wbuf[g] <= '0;
        rbuf[g] <= '0;
      end else begin
        if (strobe.wbufWr && wbufIdx == IDX_W'(g)) wbuf[g] <= hostWdata;
        if (ctlRbufWe && ctlRbufIdx == IDX_W'(g))  rbuf[g] <= ctlRbufData;
      end
    end

    // R8
    rbuf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(ctlRbufWe && ctlRbufIdx == IDX_W'(g)) |=> $stable(rbuf[g]));
  end

  assign ctlWbufData = wbuf[ctlWbufIdx];

  int addrInt;
  always_comb begin
    addrInt   = int'(hostAddr) & ~3;
    hostRdata = '0;
    if (addrInt == OFF_STAT)
      hostRdata = {8'h00, errCode, INIT_ID, cmdReg.cmdId, 2'b00, errFlag, busy};
    else if (addrInt >= OFF_RBUF && addrInt < OFF_RBUF + BUF_BYTES)
      hostRdata = rbuf[IDX_W'((addrInt - OFF_RBUF) >> 2)];
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipcmb_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int BUF_WORDS       = 4,
  parameter logic [7:0] INIT_ID = 8'h5A,
  localparam int IDX_W          = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              hostIrq,
  output logic              ctlDoorbell,
  output logic [7:0]        ctlOpcode,
  output logic              ctlIoc,
  output logic [3:0]        ctlCmdId,
  output logic [7:0]        ctlSize,
  output logic [31:0]       ctlSrcPtr,
  output logic [31:0]       ctlDstPtr,
  input  logic [IDX_W-1:0]  ctlWbufIdx,
  output logic [31:0]       ctlWbufData,
  input  logic              ctlRbufWe,
  input  logic [IDX_W-1:0]  ctlRbufIdx,
  input  logic [31:0]       ctlRbufData,
  input  logic              ctlDone,
  input  logic              ctlErr,
  input  logic [7:0]        ctlErrCode,
  output logic              ctlOverrun,
  output logic              busy
);
  hostStrobe_t      strobe;
  logic [IDX_W-1:0] wbufIdx;
  cmdWord_t         cmdReg;

  ipcmb_ctrl #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .ctlDone(ctlDone), .latchedIoc(cmdReg.ioc), .strobe(strobe),
    .wbufIdx(wbufIdx), .busy(busy), .doorbell(ctlDoorbell),
    .hostIrq(hostIrq), .overrun(ctlOverrun)
  );

  ipcmb_datapath #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS), .INIT_ID(INIT_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wbufIdx(wbufIdx),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .busy(busy),
    .ctlErr(ctlErr), .ctlErrCode(ctlErrCode), .ctlWbufIdx(ctlWbufIdx),
    .ctlRbufWe(ctlRbufWe), .ctlRbufIdx(ctlRbufIdx), .ctlRbufData(ctlRbufData),
    .cmdReg(cmdReg), .srcPtr(ctlSrcPtr), .dstPtr(ctlDstPtr),
    .ctlWbufData(ctlWbufData), .hostRdata(hostRdata)
  );

  assign ctlOpcode = cmdReg.opcode;
  assign ctlIoc    = cmdReg.ioc;
  assign ctlCmdId  = cmdReg.cmdId;
  assign ctlSize   = cmdReg.size;
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostIrq, ctlDoorbell, ctlIoc, ctlOverrun, busy;
  logic [7:0]  ctlOpcode, ctlSize;
  logic [3:0]  ctlCmdId;
  logic [31:0] ctlSrcPtr, ctlDstPtr, ctlWbufData;
  logic [1:0]  ctlWbufIdx = '0;
  logic        ctlRbufWe = 1'b0;
  logic [1:0]  ctlRbufIdx = '0;
  logic [31:0] ctlRbufData = '0;
  logic        ctlDone = 1'b0;
  logic        ctlErr = 1'b0;
  logic [7:0]  ctlErrCode = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostIrq(hostIrq),
    .ctlDoorbell(ctlDoorbell), .ctlOpcode(ctlOpcode), .ctlIoc(ctlIoc),
    .ctlCmdId(ctlCmdId), .ctlSize(ctlSize), .ctlSrcPtr(ctlSrcPtr),
    .ctlDstPtr(ctlDstPtr), .ctlWbufIdx(ctlWbufIdx), .ctlWbufData(ctlWbufData),
    .ctlRbufWe(ctlRbufWe), .ctlRbufIdx(ctlRbufIdx), .ctlRbufData(ctlRbufData),
    .ctlDone(ctlDone), .ctlErr(ctlErr), .ctlErrCode(ctlErrCode),
    .ctlOverrun(ctlOverrun), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [31:0] d);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic ctlComplete(input logic e, input logic [7:0] code);
    @(negedge clk);
    ctlDone = 1'b1; ctlErr = e; ctlErrCode = code;
    @(negedge clk);
    ctlDone = 1'b0; ctlErr = 1'b0; ctlErrCode = '0;
  endtask

  // {isWrite, addr, data, expected read}
  localparam int NVEC = 12;
  localparam logic [72:0] VECS [NVEC] = '{
    {1'b1, 8'h08, 32'h1111_2222, 32'h0},
    {1'b1, 8'h0C, 32'h3333_4444, 32'h0},
    {1'b1, 8'h88, 32'h5555_6666, 32'h0},
    {1'b0, 8'h08, 32'h0, 32'h0},
    {1'b0, 8'h0C, 32'h0, 32'h0},
    {1'b0, 8'h88, 32'h0, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h0},
    {1'b0, 8'h04, 32'h0, 32'h0000_5A00},
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h04, 32'h0, 32'h0000_5A00},
    {1'b1, 8'h94, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 8'h94, 32'h0, 32'h0}
  };

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'h0);
    check("R1 irq/doorbell/overrun", {29'b0, hostIrq, ctlDoorbell, ctlOverrun}, 32'h0);
    check("R1 pointers", ctlSrcPtr | ctlDstPtr, 32'h0);
    for (int i = 0; i < 4; i++) begin
      ctlWbufIdx = 2'(i);
      #1 check("R1 payload word", ctlWbufData, 32'h0);
      hostRead(8'h90 + 8'(4 * i), rd);
      check("R1 response word", rd, 32'h0);
    end
    hostRead(8'h04, rd);
    check("R1 R3 idle status", rd, 32'h0000_5A00);

    // table: R7 R8 R9 register access
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v][72]) hostWrite(VECS[v][71:64], VECS[v][63:32]);
      else begin
        hostRead(VECS[v][71:64], rd);
        check("R9 R8 R3 table read", rd, VECS[v][31:0]);
      end
    end
    check("R7 src pointer", ctlSrcPtr, 32'h1111_2222);
    check("R7 dst pointer", ctlDstPtr, 32'h3333_4444);
    ctlWbufIdx = 2'd2;
    #1 check("R7 payload word 2", ctlWbufData, 32'h5555_6666);

    // R2 command accept
    hostWrite(8'h00, 32'hFF03_5FA7);
    check("R2 doorbell", {31'b0, ctlDoorbell}, 32'h1);
    check("R2 opcode", {24'b0, ctlOpcode}, 32'hA7);
    check("R2 ioc", {31'b0, ctlIoc}, 32'h1);
    check("R2 cmd id", {28'b0, ctlCmdId}, 32'h5);
    check("R2 size", {24'b0, ctlSize}, 32'h03);
    hostRead(8'h04, rd);
    check("R3 busy status", rd, 32'h0000_5A51);
    @(negedge clk);
    check("R2 doorbell single", {31'b0, ctlDoorbell}, 32'h0);

    // R7 payload write while busy
    hostWrite(8'h84, 32'hCAFE_F00D);
    ctlWbufIdx = 2'd1;
    #1 check("R7 payload while busy", ctlWbufData, 32'hCAFE_F00D);

    // R6 dropped command
    hostWrite(8'h00, 32'h0000_0012);
    check("R6 no doorbell", {31'b0, ctlDoorbell}, 32'h0);
    check("R6 opcode kept", {24'b0, ctlOpcode}, 32'hA7);
    check("R6 overrun set", {31'b0, ctlOverrun}, 32'h1);

    // R8 response fill
    @(negedge clk);
    ctlRbufWe = 1'b1; ctlRbufIdx = 2'd2; ctlRbufData = 32'h1234_5678;
    @(negedge clk);
    ctlRbufWe = 1'b0;
    hostRead(8'h98, rd);
    check("R8 response read", rd, 32'h1234_5678);

    // R4 R5 completion with error and irq
    ctlComplete(1'b1, 8'h3C);
    check("R4 busy cleared", {31'b0, busy}, 32'h0);
    check("R5 irq pulse", {31'b0, hostIrq}, 32'h1);
    hostRead(8'h04, rd);
    check("R4 R3 error status", rd, 32'h003C_5A52);
    @(negedge clk);
    check("R5 irq single", {31'b0, hostIrq}, 32'h0);

    // R4 done while idle ignored
    ctlComplete(1'b0, 8'h00);
    hostRead(8'h04, rd);
    check("R4 idle done ignored", rd, 32'h003C_5A52);
    check("R5 no irq idle done", {31'b0, hostIrq}, 32'h0);

    // R5 no irq without ioc, R6 overrun sticky
    hostWrite(8'h00, 32'h0001_3010);
    check("R2 second doorbell", {31'b0, ctlDoorbell}, 32'h1);
    ctlComplete(1'b0, 8'h00);
    check("R5 no irq", {31'b0, hostIrq}, 32'h0);
    hostRead(8'h04, rd);
    check("R4 clean status", rd, 32'h0000_5A30);
    @(negedge clk);
    check("R5 no irq later", {31'b0, hostIrq}, 32'h0);
    check("R6 overrun sticky", {31'b0, ctlOverrun}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule